// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block gathers eight interrupt sources of a network controller into one status byte and drives one interrupt line to the host. Most sources are one-cycle event pulses, which the block latches until the host acknowledges them. Two sources are levels that simply track their inputs. The host reads the status byte and writes ones to the same byte address to clear latched bits. An enable byte at the next address selects which status bits may raise the interrupt line.

Source 5 is a second-level summary of protocol-handler trouble. It can be set by three conditions: a transmit error pulse, a link error pulse, and a rollover of any of four internal 4-bit statistic counters. Each of the three has its own enable bit in a control byte, and a condition whose enable is clear is dropped. The statistic counters advance on per-counter increment strobes. They exist only to produce the rollover condition.

Top module: `isu_top`

## Requirements
- R1: After reset the status byte (address 0), the enable byte (address 1), the control byte (address 2) and `irq` all read 0, provided the level inputs are low.
- R2: A write at address 1 stores the full enable byte and reads back unchanged. A write at address 2 keeps only bits 7:5, and the other control bits read 0.
- R3: A one-cycle pulse on an event source sets its status bit at the next clock edge, and the bit stays set until it is acknowledged. The event sources are bit 1 transmit done, bit 3 allocation done, bit 4 receive overrun, bit 6 early receive and bit 7 PHY change.
- R4: A write at address 0 clears each latched status bit whose data bit is 1. Latched bits whose data bit is 0 are left as they are.
- R5: Status bit 0 (receive ready) and bit 2 (transmit queue empty) show their inputs as sampled at the previous edge. An acknowledge has no effect on them.
- R6: When an event and the acknowledge of its bit arrive in the same cycle, the bit remains set.
- R7: `irq` is a register. It is 1 exactly when, in the previous cycle, some status bit and the matching enable bit were both 1.
- R8: A transmit error pulse sets status bit 5 only while control bit 5 is 1. Otherwise it is ignored.
- R9: Each statistic counter wraps after 16 increments. Any wrap sets status bit 5 only while control bit 6 is 1.
- R10: A link error pulse sets status bit 5 only while control bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Byte address: 0 status/acknowledge, 1 enable, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| src_rx_ready | input | 1 | Level: receive data pending |
| src_tx_done | input | 1 | Pulse: transmit completed |
| src_txq_empty | input | 1 | Level: transmit queue empty |
| src_alloc_done | input | 1 | Pulse: buffer allocation finished |
| src_rx_overrun | input | 1 | Pulse: receiver overrun |
| src_early_rx | input | 1 | Pulse: early receive |
| src_phy_change | input | 1 | Pulse: PHY status changed |
| cond_tx_error | input | 1 | Pulse: transmit error condition |
| cond_link_error | input | 1 | Pulse: link error condition |
| stat_inc | input | 4 | Increment strobes of the four statistic counters |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: four statistic counters of 4 bits each and an 8-bit data path. With these values a rollover takes only 16 strobes, so the test can stop one strobe short of the wrap, then make the wrap, and then repeat the wrap with its enable clear, all in a few dozen cycles. The 8-bit width lets every status and enable bit be driven, including a same-cycle collision between an event and its acknowledge.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_CNT  = 4;
    localparam int CNT_W    = 4;
    localparam int ADDR_W   = 2;

    // Bit positions in the status byte
    localparam int B_RX_READY  = 0;
    localparam int B_TX_DONE   = 1;
    localparam int B_TXQ_EMPTY = 2;
    localparam int B_ALLOC     = 3;
    localparam int B_OVERRUN   = 4;
    localparam int B_SUMMARY   = 5;
    localparam int B_EARLY_RX  = 6;
    localparam int B_PHY       = 7;

    // Control byte enables for the summary conditions
    localparam int C_TXERR_EN = 5;
    localparam int C_ROLL_EN  = 6;
    localparam int C_LINK_EN  = 7;

    localparam logic [DATA_W-1:0] LEVEL_BITS =
        DATA_W'((1 << B_RX_READY) | (1 << B_TXQ_EMPTY));
    localparam logic [DATA_W-1:0] CTRL_KEEP =
        DATA_W'((1 << C_TXERR_EN) | (1 << C_ROLL_EN) | (1 << C_LINK_EN));

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 2'd0,
        RA_ENABLE = 2'd1,
        RA_CTRL   = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic link_err;
        logic rollover;
        logic tx_err;
    } sum_cond_t;

    typedef struct packed {
        logic link_en;
        logic roll_en;
        logic txerr_en;
    } sum_en_t;

    function automatic sum_en_t ctrl_to_en(input logic [DATA_W-1:0] c);
        sum_en_t e;
        e.txerr_en = c[C_TXERR_EN];
        e.roll_en  = c[C_ROLL_EN];
        e.link_en  = c[C_LINK_EN];
        return e;
    endfunction

    function automatic logic sum_fire(input sum_cond_t c, input sum_en_t e);
        return (c.tx_err & e.txerr_en) | (c.rollover & e.roll_en) |
               (c.link_err & e.link_en);
    endfunction

endpackage

// File: rtl/isu_rollover.sv
module isu_rollover
    import isu_pkg::*;
#(
    parameter int N_CNT = NUM_CNT,
    parameter int W_CNT = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CNT-1:0] inc,
    output logic             wrap
);
    localparam logic [W_CNT-1:0] TOP = {W_CNT{1'b1}};

    logic [N_CNT-1:0] wrap_vec;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        logic [W_CNT-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q <= '0;
            else if (inc[g])
                cnt_q <= cnt_q + 1'b1;
        end
        assign wrap_vec[g] = inc[g] && (cnt_q == TOP);
    end

    assign wrap = |wrap_vec;
endmodule

// File: rtl/isu_summary.sv
module isu_summary
    import isu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_err,
    input  logic               link_err,
    input  logic [NUM_CNT-1:0] stat_inc,
    input  logic [DATA_W-1:0]  ctrl,
    output logic               sum_evt
);
    logic      wrap;
    sum_cond_t cond;

    isu_rollover #(.N_CNT(NUM_CNT), .W_CNT(CNT_W)) u_roll (
        .clk  (clk),
        .rst  (rst),
        .inc  (stat_inc),
        .wrap (wrap)
    );

    always_comb begin
        cond.tx_err   = tx_err;
        cond.rollover = wrap;
        cond.link_err = link_err;
        sum_evt = sum_fire(cond, ctrl_to_en(ctrl));
    end
endmodule

// File: rtl/isu_cfg.sv
module isu_cfg
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] enable_q,
    output logic [DATA_W-1:0] ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            ctrl_q   <= '0;
        end else if (wr) begin
            if (addr == RA_ENABLE) enable_q <= wdata;
            if (addr == RA_CTRL)   ctrl_q   <= wdata & CTRL_KEEP;
        end
    end
endmodule

// File: rtl/isu_status.sv
module isu_status
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] evt,
    input  logic [DATA_W-1:0] lvl,
    input  logic              ack_wr,
    input  logic [DATA_W-1:0] ack_data,
    input  logic [DATA_W-1:0] enable,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (LEVEL_BITS[i]) begin : g_lvl
            always_ff @(posedge clk) begin
                if (rst) status[i] <= 1'b0;
                else     status[i] <= lvl[i];
            end
        end else begin : g_sticky
            logic clr;
            assign clr = ack_wr & ack_data[i];
            always_ff @(posedge clk) begin
                if (rst)         status[i] <= 1'b0;
                else if (evt[i]) status[i] <= 1'b1;
                else if (clr)    status[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status & enable);
    end
endmodule

// File: rtl/isu_top.sv
module isu_top
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              src_rx_ready,
    input  logic              src_tx_done,
    input  logic              src_txq_empty,
    input  logic              src_alloc_done,
    input  logic              src_rx_overrun,
    input  logic              src_early_rx,
    input  logic              src_phy_change,
    input  logic              cond_tx_error,
    input  logic              cond_link_error,
    input  logic [NUM_CNT-1:0] stat_inc,
    output logic              irq
);
    logic [DATA_W-1:0] enable_q, ctrl_q, status, evt, lvl;
    logic              sum_evt, ack_wr;

    isu_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .enable_q (enable_q),
        .ctrl_q   (ctrl_q)
    );

    isu_summary u_sum (
        .clk      (clk),
        .rst      (rst),
        .tx_err   (cond_tx_error),
        .link_err (cond_link_error),
        .stat_inc (stat_inc),
        .ctrl     (ctrl_q),
        .sum_evt  (sum_evt)
    );

    always_comb begin
        evt = '0;
        evt[B_TX_DONE]  = src_tx_done;
        evt[B_ALLOC]    = src_alloc_done;
        evt[B_OVERRUN]  = src_rx_overrun;
        evt[B_SUMMARY]  = sum_evt;
        evt[B_EARLY_RX] = src_early_rx;
        evt[B_PHY]      = src_phy_change;
        lvl = '0;
        lvl[B_RX_READY]  = src_rx_ready;
        lvl[B_TXQ_EMPTY] = src_txq_empty;
    end

    assign ack_wr = bus_wr && (bus_addr == RA_STATUS);

    isu_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .lvl      (lvl),
        .ack_wr   (ack_wr),
        .ack_data (bus_wdata),
        .enable   (enable_q),
        .status   (status),
        .irq      (irq)
    );

    always_comb begin
        case (bus_addr)
            RA_STATUS: bus_rdata = status;
            RA_ENABLE: bus_rdata = enable_q;
            RA_CTRL:   bus_rdata = ctrl_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/isu_checker.sv
module isu_checker
    import isu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              src_rx_ready,
    input logic              src_tx_done,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] enable_q,
    input logic              sum_evt,
    input logic              irq
);
    logic ack3;
    assign ack3 = bus_wr && (bus_addr == RA_STATUS) && bus_wdata[B_ALLOC];

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq == $past(|(status & enable_q))));

    assert_level_tracks_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status[B_RX_READY] == $past(src_rx_ready)));

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
        src_tx_done |=> status[B_TX_DONE]);

    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (status[B_ALLOC] && !ack3) |=> status[B_ALLOC]);

    assert_summary_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (!status[B_SUMMARY] && !sum_evt) |=> !status[B_SUMMARY]);
endmodule

bind isu_top isu_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .src_rx_ready (src_rx_ready),
    .src_tx_done  (src_tx_done),
    .status       (status),
    .enable_q     (enable_q),
    .sum_evt      (sum_evt),
    .irq          (irq)
);

// File: tb/isu_top_test.sv
module isu_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic src_rx_ready = 0, src_tx_done = 0, src_txq_empty = 0, src_alloc_done = 0;
    logic src_rx_overrun = 0, src_early_rx = 0, src_phy_change = 0;
    logic cond_tx_error = 0, cond_link_error = 0;
    logic [3:0] stat_inc = 4'h0;
    logic irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    isu_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_rx_ready(src_rx_ready), .src_tx_done(src_tx_done),
        .src_txq_empty(src_txq_empty), .src_alloc_done(src_alloc_done),
        .src_rx_overrun(src_rx_overrun), .src_early_rx(src_early_rx),
        .src_phy_change(src_phy_change), .cond_tx_error(cond_tx_error),
        .cond_link_error(cond_link_error), .stat_inc(stat_inc), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R1 status", v, 8'h00);
        rd(2'd1, v); chk("R1 enable", v, 8'h00);
        rd(2'd2, v); chk("R1 control", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 enable readback", v, 8'hA5);
        wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 control keeps 7:5", v, 8'hE0);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_events();
        logic [7:0] v;
        src_tx_done = 1; tick(); src_tx_done = 0;
        rd(2'd0, v); chk("R3 tx done set", v, 8'h02);
        tick(); rd(2'd0, v); chk("R3 tx done held", v, 8'h02);
        src_alloc_done = 1; src_rx_overrun = 1; src_early_rx = 1; src_phy_change = 1;
        tick();
        src_alloc_done = 0; src_rx_overrun = 0; src_early_rx = 0; src_phy_change = 0;
        rd(2'd0, v); chk("R3 all events", v, 8'hDA);
        wr(2'd0, 8'h0A); rd(2'd0, v); chk("R4 partial ack", v, 8'hD0);
        wr(2'd0, 8'h00); rd(2'd0, v); chk("R4 zero ack", v, 8'hD0);
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R4 full ack", v, 8'h00);
    endtask

    task automatic t_levels();
        logic [7:0] v;
        src_rx_ready = 1; src_txq_empty = 1; tick();
        rd(2'd0, v); chk("R5 levels high", v, 8'h05);
        wr(2'd0, 8'h05); rd(2'd0, v); chk("R5 ack ignored", v, 8'h05);
        src_rx_ready = 0; src_txq_empty = 0; tick();
        rd(2'd0, v); chk("R5 levels low", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        src_tx_done = 1; tick(); src_tx_done = 0;
        src_tx_done = 1; wr(2'd0, 8'h02); src_tx_done = 0;
        rd(2'd0, v); chk("R6 event beats ack", v, 8'h02);
        wr(2'd0, 8'h02); rd(2'd0, v); chk("R6 later ack clears", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(2'd1, 8'h08);
        src_alloc_done = 1; tick(); src_alloc_done = 0;
        chk("R7 irq registered", {7'd0, irq}, 8'h00);
        tick(); chk("R7 irq raised", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h00); chk("R7 irq one cycle late", {7'd0, irq}, 8'h01);
        tick(); chk("R7 irq masked off", {7'd0, irq}, 8'h00);
        rd(2'd0, v); chk("R7 status unaffected by mask", v, 8'h08);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_summary();
        logic [7:0] v;
        cond_tx_error = 1; cond_link_error = 1; tick();
        cond_tx_error = 0; cond_link_error = 0;
        rd(2'd0, v); chk("R8 R10 disabled ignored", v, 8'h00);
        wr(2'd2, 8'h20);
        cond_tx_error = 1; tick(); cond_tx_error = 0;
        rd(2'd0, v); chk("R8 tx error enabled", v, 8'h20);
        wr(2'd0, 8'h20);
        wr(2'd2, 8'h80);
        cond_tx_error = 1; tick(); cond_tx_error = 0;
        rd(2'd0, v); chk("R8 tx error not enabled", v, 8'h00);
        cond_link_error = 1; tick(); cond_link_error = 0;
        rd(2'd0, v); chk("R10 link error enabled", v, 8'h20);
        wr(2'd0, 8'h20);
    endtask

    task automatic t_roll();
        logic [7:0] v;
        wr(2'd2, 8'h40);
        for (int i = 0; i < 15; i++) begin
            stat_inc = 4'b0100; tick(); stat_inc = 4'h0;
        end
        rd(2'd0, v); chk("R9 no wrap after 15", v, 8'h00);
        stat_inc = 4'b0100; tick(); stat_inc = 4'h0;
        rd(2'd0, v); chk("R9 wrap on 16th", v, 8'h20);
        wr(2'd0, 8'h20);
        wr(2'd2, 8'h00);
        for (int i = 0; i < 16; i++) begin
            stat_inc = 4'b0001; tick(); stat_inc = 4'h0;
        end
        rd(2'd0, v); chk("R9 wrap disabled", v, 8'h00);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_regs();
        t_events();
        t_levels();
        t_collide();
        t_irq();
        t_summary();
        t_roll();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule